// File: doc/BRIEF.md
# Delayed Read Request Holder

A host read that the local side cannot answer at once is captured by this block. The host gets a retry, and the block fetches the data over a simple request/acknowledge local port. When the host repeats the same read, the block returns the latched data in that cycle. Only one read can be outstanding at a time. Any other read that arrives while a read is held is answered with retry.

A configuration bit sets what happens to data that has arrived when an unrelated transaction comes first. With the bit clear, the held read is dropped. With the bit set, the held read is kept until the original read returns or a programmable timeout expires. A write to the held address makes the held read invalid under either setting. When the timeout drops a held read, an interrupt pulse can be raised.

Top module: `drq_holder`

## Requirements
- R1: After reset the holder is empty: `l_req`, `tmo_irq`, `h_retry` and `h_done` are all 0 while no host request is present.
- R2: A host read (`h_req`=1, `h_write`=0) to an empty holder is answered with `h_retry`=1 in that cycle. From the next cycle, `l_req` is 1 and `l_addr`/`l_be` carry the captured address and byte enables. `l_req` stays 1 until the cycle in which `l_ack`=1.
- R3: While the local fetch is still in progress, a repeat of the captured read is answered with `h_retry`=1 and `h_done`=0.
- R4: Once data has arrived, a read whose address and byte enables both equal the captured ones gets `h_done`=1, `h_retry`=0 and `h_rdata` equal to the `l_rdata` value sampled with `l_ack`. The holder is then empty, so the next identical read is retried again.
- R5: With `cfg_hold`=0 and data present, any host request other than the exact repeat drops the data. If that request is a read, it is captured as the new held read and retried. A differing byte-enable value counts as a different request.
- R6: With `cfg_hold`=1 and data present, other host requests leave the data intact. Other reads get `h_retry`=1, and a later exact repeat is still served with the original data.
- R7: A host write whose address equals the captured address makes the held read invalid. This applies whether the data has arrived or is still being fetched. The next read to that address is retried and fetched anew.
- R8: The timeout counter starts in the first cycle after data arrives. With limit N = `cfg_tmo` (a value of 0 is treated as 1), the held data expires at the end of the N-th cycle it has been held. A read after that is retried.
- R9: `tmo_irq` is 1 for exactly the one cycle after a timeout expiry, and only if `cfg_irq_en`=1. Discards that other requests cause never raise it.
- R10: While a fetch is in progress, a read to a different address is retried and is not captured. `l_addr` keeps the original address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hold | input | 1 | 0: drop fetched data on an unrelated request; 1: keep it |
| cfg_irq_en | input | 1 | Enables the timeout-discard interrupt |
| cfg_tmo | input | TW (12) | Hold timeout in cycles (0 acts as 1) |
| h_req | input | 1 | Host transaction present this cycle |
| h_write | input | 1 | 1 for a host write, 0 for a read |
| h_addr | input | AW (16) | Host address |
| h_be | input | BEW (4) | Host byte enables |
| h_retry | output | 1 | Host read must be retried |
| h_done | output | 1 | Host read completes with `h_rdata` |
| h_rdata | output | DW (32) | Held read data |
| l_req | output | 1 | Local fetch request |
| l_addr | output | AW (16) | Local fetch address |
| l_be | output | BEW (4) | Local fetch byte enables |
| l_ack | input | 1 | Local data valid, ends the fetch |
| l_rdata | input | DW (32) | Local read data |
| tmo_irq | output | 1 | One-cycle timeout-discard interrupt |

## Verification
The hardest case to reach from the ports is a write to the held address that lands while the fetch is still open. The kill has to survive until the acknowledge comes back, so that the returned data is thrown away rather than served. The stimulus issues the read, then the matching write before `l_ack`, and only then acknowledges. A repeat read must come back as retry and start a new fetch. The timeout is reached by holding data with `cfg_tmo` set to 5 and to 0, and counting idle cycles up to the interrupt pulse.

// File: rtl/drq_pkg.sv
package drq_pkg;

    localparam int DRQ_AW  = 16;
    localparam int DRQ_BEW = 4;
    localparam int DRQ_DW  = 32;
    localparam int DRQ_TW  = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_READY = 2'd2
    } state_t;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_CAPTURE = 3'd1,
        ACT_LAND    = 3'd2,
        ACT_SERVE   = 3'd3,
        ACT_INVAL   = 3'd4,
        ACT_DISCARD = 3'd5,
        ACT_EXPIRE  = 3'd6
    } act_t;

    function automatic state_t next_of(input act_t a, input state_t cur);
        case (a)
            ACT_CAPTURE: next_of = ST_FETCH;
            ACT_LAND:    next_of = ST_READY;
            ACT_SERVE,
            ACT_INVAL,
            ACT_DISCARD,
            ACT_EXPIRE:  next_of = ST_IDLE;
            default:     next_of = cur;
        endcase
    endfunction

endpackage

// File: rtl/drq_match.sv
module drq_match #(
    parameter int AW  = drq_pkg::DRQ_AW,
    parameter int BEW = drq_pkg::DRQ_BEW
) (
    input  logic [AW-1:0]  q_addr,
    input  logic [BEW-1:0] q_be,
    input  logic [AW-1:0]  h_addr,
    input  logic [BEW-1:0] h_be,
    input  logic           h_write,
    output logic           addr_hit,
    output logic           full_hit
);
    logic [BEW-1:0] lane_eq;

    genvar g;
    generate
        for (g = 0; g < BEW; g++) begin : g_lane
            assign lane_eq[g] = (q_be[g] == h_be[g]);
        end
    endgenerate

    assign addr_hit = (q_addr == h_addr);
    assign full_hit = addr_hit && (&lane_eq) && !h_write;
endmodule

// File: rtl/drq_timer.sv
module drq_timer #(
    parameter int TW = drq_pkg::DRQ_TW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;
    logic [TW:0]   lim_eff;
    logic [TW:0]   cnt_nxt;

    assign lim_eff = (limit == '0) ? (TW+1)'(1) : {1'b0, limit};
    assign cnt_nxt = {1'b0, cnt} + (TW+1)'(1);
    assign expire  = run && (cnt_nxt >= lim_eff);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt_nxt[TW-1:0];
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> ({1'b0, cnt} < lim_eff)); // R8
endmodule

// File: rtl/drq_ctrl.sv
module drq_ctrl
    import drq_pkg::*;
#(
    parameter int AW  = DRQ_AW,
    parameter int BEW = DRQ_BEW,
    parameter int DW  = DRQ_DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_hold,
    input  logic           cfg_irq_en,
    input  logic           h_req,
    input  logic           h_write,
    input  logic [AW-1:0]  h_addr,
    input  logic [BEW-1:0] h_be,
    input  logic           addr_hit,
    input  logic           full_hit,
    input  logic           l_ack,
    input  logic [DW-1:0]  l_rdata,
    input  logic           expire,
    output state_t         st,
    output logic [AW-1:0]  q_addr,
    output logic [BEW-1:0] q_be,
    output logic [DW-1:0]  q_data,
    output logic           irq,
    output logic           h_retry,
    output logic           h_done,
    output logic           l_req
);
    act_t act;
    logic is_rd, is_wr, wr_hit, kill_q;

    assign is_rd  = h_req && !h_write;
    assign is_wr  = h_req && h_write;
    assign wr_hit = is_wr && addr_hit;

    always_comb begin
        act = ACT_NONE;
        case (st)
            ST_IDLE: begin
                if (is_rd) act = ACT_CAPTURE;
            end
            ST_FETCH: begin
                if (l_ack) act = (kill_q || wr_hit) ? ACT_INVAL : ACT_LAND;
            end
            ST_READY: begin
                if (is_rd && full_hit)     act = ACT_SERVE;
                else if (wr_hit)           act = ACT_INVAL;
                else if (h_req && !cfg_hold) act = is_rd ? ACT_CAPTURE : ACT_DISCARD;
                else if (expire)           act = ACT_EXPIRE;
            end
            default: act = ACT_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            q_addr <= '0;
            q_be   <= '0;
            q_data <= '0;
            kill_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            st  <= next_of(act, st);
            irq <= (act == ACT_EXPIRE) && cfg_irq_en;
            if (act == ACT_CAPTURE) begin
                q_addr <= h_addr;
                q_be   <= h_be;
                kill_q <= 1'b0;
            end else if (st == ST_FETCH && wr_hit) begin
                kill_q <= 1'b1;
            end
            if (act == ACT_LAND) q_data <= l_rdata;
        end
    end

    assign h_done  = is_rd && (st == ST_READY) && full_hit;
    assign h_retry = is_rd && !h_done;
    assign l_req   = (st == ST_FETCH);

    AST_LREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (l_req && !l_ack) |=> l_req); // R2
    AST_LREQ_START: assert property (@(posedge clk) disable iff (rst)
        $rose(l_req) |-> $past(is_rd)); // R2
    AST_SERVE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        h_done |=> (st == ST_IDLE)); // R4
    AST_WRITE_INVAL: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READY && wr_hit) |=> (st == ST_IDLE)); // R7
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READY && cfg_hold && h_req && !addr_hit && !expire) |=> (st == ST_READY)); // R6
    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH && !l_ack) |=> $stable(q_addr)); // R10
endmodule

// File: rtl/drq_holder.sv
module drq_holder
    import drq_pkg::*;
#(
    parameter int AW  = DRQ_AW,
    parameter int BEW = DRQ_BEW,
    parameter int DW  = DRQ_DW,
    parameter int TW  = DRQ_TW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_hold,
    input  logic           cfg_irq_en,
    input  logic [TW-1:0]  cfg_tmo,
    input  logic           h_req,
    input  logic           h_write,
    input  logic [AW-1:0]  h_addr,
    input  logic [BEW-1:0] h_be,
    output logic           h_retry,
    output logic           h_done,
    output logic [DW-1:0]  h_rdata,
    output logic           l_req,
    output logic [AW-1:0]  l_addr,
    output logic [BEW-1:0] l_be,
    input  logic           l_ack,
    input  logic [DW-1:0]  l_rdata,
    output logic           tmo_irq
);
    state_t         st;
    logic [AW-1:0]  q_addr;
    logic [BEW-1:0] q_be;
    logic           addr_hit, full_hit, expire;

    drq_match #(.AW(AW), .BEW(BEW)) u_match (
        .q_addr   (q_addr),
        .q_be     (q_be),
        .h_addr   (h_addr),
        .h_be     (h_be),
        .h_write  (h_write),
        .addr_hit (addr_hit),
        .full_hit (full_hit)
    );

    drq_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (st == ST_READY),
        .limit  (cfg_tmo),
        .expire (expire)
    );

    drq_ctrl #(.AW(AW), .BEW(BEW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_hold   (cfg_hold),
        .cfg_irq_en (cfg_irq_en),
        .h_req      (h_req),
        .h_write    (h_write),
        .h_addr     (h_addr),
        .h_be       (h_be),
        .addr_hit   (addr_hit),
        .full_hit   (full_hit),
        .l_ack      (l_ack),
        .l_rdata    (l_rdata),
        .expire     (expire),
        .st         (st),
        .q_addr     (q_addr),
        .q_be       (q_be),
        .q_data     (h_rdata),
        .irq        (tmo_irq),
        .h_retry    (h_retry),
        .h_done     (h_done),
        .l_req      (l_req)
    );

    assign l_addr = q_addr;
    assign l_be   = q_be;

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tmo_irq |-> ($past(expire) && $past(cfg_irq_en))); // R9
    AST_RESP_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({h_retry, h_done})); // R3
endmodule

// File: tb/drq_holder_tb.sv
module drq_holder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_hold, cfg_irq_en;
    logic [11:0] cfg_tmo;
    logic        h_req, h_write;
    logic [15:0] h_addr;
    logic [3:0]  h_be;
    logic        h_retry, h_done;
    logic [31:0] h_rdata;
    logic        l_req;
    logic [15:0] l_addr;
    logic [3:0]  l_be;
    logic        l_ack;
    logic [31:0] l_rdata;
    logic        tmo_irq;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    drq_holder u_dut (
        .clk(clk), .rst(rst), .cfg_hold(cfg_hold), .cfg_irq_en(cfg_irq_en),
        .cfg_tmo(cfg_tmo), .h_req(h_req), .h_write(h_write), .h_addr(h_addr),
        .h_be(h_be), .h_retry(h_retry), .h_done(h_done), .h_rdata(h_rdata),
        .l_req(l_req), .l_addr(l_addr), .l_be(l_be), .l_ack(l_ack),
        .l_rdata(l_rdata), .tmo_irq(tmo_irq)
    );

    typedef struct packed {
        logic        req;
        logic        wr;
        logic [15:0] a;
        logic [3:0]  be;
        logic        ack;
        logic [31:0] d;
        logic        e_rty;
        logic        e_done;
        logic        e_lreq;
        logic [31:0] e_rd;
    } vec_t;

    // cfg_hold=0; one row per cycle
    localparam vec_t VEC [15] = '{
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 32'h0},        // idle
        '{1'b1, 1'b0, 16'h0010, 4'hF, 1'b0, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0},        // R2 capture
        '{1'b1, 1'b0, 16'h0010, 4'hF, 1'b0, 32'h0,        1'b1, 1'b0, 1'b1, 32'h0},        // R3 repeat in fetch
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b1, 32'hCAFE0001, 1'b0, 1'b0, 1'b1, 32'h0},        // data lands
        '{1'b1, 1'b0, 16'h0010, 4'h3, 1'b0, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0},        // R5 be differs
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b1, 32'h12345678, 1'b0, 1'b0, 1'b1, 32'h0},
        '{1'b1, 1'b0, 16'h0010, 4'h3, 1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 32'h12345678}, // R4 served
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 32'h0},
        '{1'b1, 1'b0, 16'h0020, 4'hF, 1'b0, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0},
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b1, 32'h00000055, 1'b0, 1'b0, 1'b1, 32'h0},
        '{1'b1, 1'b1, 16'h0020, 4'hF, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 32'h0},        // R7 write hit
        '{1'b1, 1'b0, 16'h0020, 4'hF, 1'b0, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0},        // R7 refetch
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b1, 32'h00000066, 1'b0, 1'b0, 1'b1, 32'h0},
        '{1'b1, 1'b0, 16'h0020, 4'hF, 1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 32'h00000066},
        '{1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, leave 5 ns for outputs to settle before sampling
    task automatic drive(input logic req, input logic wr, input logic [15:0] a,
                         input logic [3:0] be, input logic ack, input logic [31:0] d);
        @(negedge clk);
        h_req = req; h_write = wr; h_addr = a; h_be = be; l_ack = ack; l_rdata = d;
        #5;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 16'h0, 4'h0, 1'b0, 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        h_req = 0; h_write = 0; h_addr = 0; h_be = 0; l_ack = 0; l_rdata = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        cfg_hold = 0; cfg_irq_en = 1; cfg_tmo = 12'd100;
        do_reset();

        // R1 reset state
        idle();
        chk("R1 l_req", l_req, 0);
        chk("R1 tmo_irq", tmo_irq, 0);
        chk("R1 h_retry", h_retry, 0);
        chk("R1 h_done", h_done, 0);

        // table walk: R2 R3 R4 R5 R7
        for (int i = 0; i < 15; i++) begin
            drive(VEC[i].req, VEC[i].wr, VEC[i].a, VEC[i].be, VEC[i].ack, VEC[i].d);
            chk($sformatf("R2/R3/R4/R5/R7 row %0d retry", i), h_retry, VEC[i].e_rty);
            chk($sformatf("R2/R3/R4/R5/R7 row %0d done", i), h_done, VEC[i].e_done);
            chk($sformatf("R2/R3/R4/R5/R7 row %0d l_req", i), l_req, VEC[i].e_lreq);
            if (VEC[i].e_done)
                chk($sformatf("R4 row %0d rdata", i), h_rdata, VEC[i].e_rd);
        end

        // R2 captured address/be on local port; R10 other read in fetch not captured
        do_reset();
        drive(1, 0, 16'h0040, 4'h5, 0, 0);
        drive(1, 0, 16'h0050, 4'hF, 0, 0);
        chk("R2 l_addr", l_addr, 16'h0040);
        chk("R2 l_be", l_be, 4'h5);
        chk("R10 other read retried", h_retry, 1);
        idle();
        chk("R10 l_addr kept", l_addr, 16'h0040);
        chk("R2 l_req held", l_req, 1);
        drive(0, 0, 0, 0, 1, 32'h0000000A);
        // R6 hold=1: other read and other write keep the data
        cfg_hold = 1;
        drive(1, 0, 16'h0044, 4'hF, 0, 0);
        chk("R6 other read retried", h_retry, 1);
        drive(1, 1, 16'h0048, 4'hF, 0, 0);
        drive(1, 0, 16'h0040, 4'h5, 0, 0);
        chk("R6 original served", h_done, 1);
        chk("R6 data kept", h_rdata, 32'h0000000A);
        cfg_hold = 0;

        // R5 hold=0: write elsewhere discards
        do_reset();
        drive(1, 0, 16'h0060, 4'hF, 0, 0);
        drive(0, 0, 0, 0, 1, 32'h7);
        drive(1, 1, 16'h0064, 4'hF, 0, 0);
        drive(1, 0, 16'h0060, 4'hF, 0, 0);
        chk("R5 write elsewhere drops", h_retry, 1);

        // R7 write to held address while still fetching
        do_reset();
        drive(1, 0, 16'h0070, 4'hF, 0, 0);
        drive(1, 1, 16'h0070, 4'hF, 0, 0);
        drive(0, 0, 0, 0, 1, 32'h9);
        drive(1, 0, 16'h0070, 4'hF, 0, 0);
        chk("R7 in-flight kill retry", h_retry, 1);
        chk("R7 in-flight kill no done", h_done, 0);
        idle();
        chk("R7 refetch started", l_req, 1);

        // R8 R9 timeout 5 with interrupt
        do_reset();
        cfg_tmo = 12'd5; cfg_irq_en = 1;
        drive(1, 0, 16'h0080, 4'hF, 0, 0);
        drive(0, 0, 0, 0, 1, 32'h8);
        for (int k = 1; k <= 5; k++) begin
            idle();
            chk($sformatf("R9 no early irq %0d", k), tmo_irq, 0);
        end
        idle();
        chk("R9 irq pulse", tmo_irq, 1);
        chk("R8 holder empty", l_req, 0);
        drive(1, 0, 16'h0080, 4'hF, 0, 0);
        chk("R9 irq one cycle", tmo_irq, 0);
        chk("R8 expired read retried", h_retry, 1);

        // R8 data still served on the last held cycle (limit 5)
        do_reset();
        drive(1, 0, 16'h0090, 4'hF, 0, 0);
        drive(0, 0, 0, 0, 1, 32'h91);
        for (int k = 1; k <= 4; k++) idle();
        drive(1, 0, 16'h0090, 4'hF, 0, 0);
        chk("R8 served in last cycle", h_done, 1);
        idle();
        chk("R9 no irq after serve", tmo_irq, 0);

        // R9 disabled, R8 limit 0 acts as 1
        do_reset();
        cfg_tmo = 12'd0; cfg_irq_en = 0;
        drive(1, 0, 16'h00A0, 4'hF, 0, 0);
        drive(0, 0, 0, 0, 1, 32'hA);
        idle();
        drive(1, 0, 16'h00A0, 4'hF, 0, 0);
        chk("R8 zero limit expired", h_retry, 1);
        chk("R9 disabled no irq", tmo_irq, 0);

        // R9 discard by request raises no irq
        do_reset();
        cfg_tmo = 12'd50; cfg_irq_en = 1;
        drive(1, 0, 16'h00B0, 4'hF, 0, 0);
        drive(0, 0, 0, 0, 1, 32'hB);
        drive(1, 1, 16'h00B4, 4'hF, 0, 0);
        idle();
        chk("R9 no irq on request discard", tmo_irq, 0);

        finished = 1;
        summary();
    end
endmodule